// File: doc/BRIEF.md
# Self-timed EEPROM register controller

This block connects a 64-byte on-chip data EEPROM to a simple CPU I/O bus through three byte-wide registers: an address register, a data register and a control register. To read a byte, software loads the address and sets the read bit in the control register. The byte then appears in the data register one cycle later. A write needs two steps. Software first arms the master enable bit. Within a short window it then sets the write bit, which copies the data register into the addressed byte. The busy bit stays set for a programmable number of cycles, standing in for the programming delay.

Each accepted access drives a stall output for a fixed number of cycles: two for a write and four for a read. A ready interrupt request stays high for as long as no write is in progress, provided software has enabled it and the global interrupt enable input is high. The array is held in flops, and the programming delay is the parameter `WR_CYCLES`.

Top module: `eeprom_io_ctrl`

## Requirements
- R1: Register reads are combinational from `io_addr` while `io_re` is high. Offset 0x1E returns the address register, 0x1D the data register and 0x1C the control register. Any other offset returns 0, and `io_rdata` is 0 whenever `io_re` is low.
- R2: The address register holds 6 writable bits (byte 0 to 63), written from `io_wdata[5:0]`. Bits 7:6 always read 0. Its contents survive reset.
- R3: The data register resets to 0. A bus write to offset 0x1D loads it.
- R4: Control bit 1 (write start) launches a write only if control bit 2 (master enable) was already set before that bus write. Setting both bits in one bus write launches nothing. A refused start leaves bit 1 reading 0.
- R5: Writing control with bit 2 set arms the master enable for `MWE_WINDOW` (default 4) cycles. A write start is accepted in the fourth cycle after arming and refused in the fifth. The enable also clears when a write launches, or when control is written with bit 2 at 0.
- R6: A launched write stores the data register at the current address and reads back later. Control bit 1 reads 1 for exactly `WR_CYCLES` cycles after the launch, then clears.
- R7: Setting control bit 0 (read start) while idle loads the addressed byte into the data register at the next edge. Bit 0 reads 1 for exactly one cycle.
- R8: A read start while a write is busy is ignored. The data register and bit 0 stay unchanged.
- R9: `cpu_stall` is high for exactly 2 cycles after a write launches and exactly 4 cycles after a read starts.
- R10: `ee_rdy_irq` equals control bit 3 (interrupt enable) AND `gie` AND NOT write-busy.
- R11: After reset, control reads 0 and both `cpu_stall` and `ee_rdy_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 6 | I/O register offset |
| io_we | input | 1 | Bus write strobe |
| io_re | input | 1 | Bus read strobe |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Bus read data |
| gie | input | 1 | Global interrupt enable from the CPU |
| cpu_stall | output | 1 | Holds the CPU while an access is started |
| ee_rdy_irq | output | 1 | Level-sensitive ready interrupt request |

## Verification
The hardest case to reach is the edge of the arming window. A write start must land on exactly the fourth or exactly the fifth cycle after the enable was armed, so the stimulus drives the bus one cycle at a time with a precise number of idle cycles between the arming write and the start. A second hard case is a read start issued while a write is busy. To reach it, the bench launches a write and issues the read within the busy period. It then reads the data register to confirm it kept the value written just before.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  localparam int unsigned IO_AW = 6;

  localparam logic [IO_AW-1:0] OFS_ADDR = 6'h1E;
  localparam logic [IO_AW-1:0] OFS_DATA = 6'h1D;
  localparam logic [IO_AW-1:0] OFS_CTRL = 6'h1C;

  // control register bit positions
  localparam int unsigned CB_RD  = 0;
  localparam int unsigned CB_WR  = 1;
  localparam int unsigned CB_ARM = 2;
  localparam int unsigned CB_IE  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/ee_rst_sync.sv
module ee_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ee_countdown.sv
module ee_countdown #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] load_val,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | load | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (clr)                cnt_d = '0;
    else if (load)          cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_io_ctrl.sv
module eeprom_io_ctrl
  import eectl_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned WR_CYCLES  = 40,
  parameter int unsigned MWE_WINDOW = 4,
  parameter int unsigned WR_STALL   = 2,
  parameter int unsigned RD_STALL   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_we,
  input  logic             io_re,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic             gie,
  output logic             cpu_stall,
  output logic             ee_rdy_irq
);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned TW     = $clog2(WR_CYCLES + 1);
  localparam int unsigned MW     = $clog2(MWE_WINDOW + 1);
  localparam int unsigned ST_MAX = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
  localparam int unsigned SW     = $clog2(ST_MAX + 1);

  // ---------------------------------------------------------------- reset
  logic rst_n_int;

  ee_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_n_int)
  );

  // ---------------------------------------------------------------- decode
  reg_sel_t sel;
  logic     addr_wr, data_wr, ctrl_wr;

  always_comb begin
    case (io_addr)
      OFS_ADDR: sel = SEL_ADDR;
      OFS_DATA: sel = SEL_DATA;
      OFS_CTRL: sel = SEL_CTRL;
      default:  sel = SEL_NONE;
    endcase
  end

  assign addr_wr = io_we && (sel == SEL_ADDR);
  assign data_wr = io_we && (sel == SEL_DATA);
  assign ctrl_wr = io_we && (sel == SEL_CTRL);

  // ---------------------------------------------------------------- state
  logic [AW-1:0] ear_q;
  logic [DW-1:0] edr_q, edr_d;
  logic          ie_q, ie_d;
  logic          rd_pend_q, rd_pend_d;
  logic          arm_act, wr_busy;
  logic          start_w, start_r;
  logic [DW-1:0] arr_rdata;

  assign start_w = ctrl_wr && io_wdata[CB_WR] && arm_act && !wr_busy;
  assign start_r = ctrl_wr && io_wdata[CB_RD] && !wr_busy && !start_w;

  // address register: no reset, contents kept through reset
  always_ff @(posedge clk) begin
    if (addr_wr) ear_q <= io_wdata[AW-1:0];
  end

  always_comb begin
    edr_d     = edr_q;
    if (rd_pend_q)    edr_d = arr_rdata;
    else if (data_wr) edr_d = io_wdata;
    ie_d      = ctrl_wr ? io_wdata[CB_IE] : ie_q;
    rd_pend_d = start_r;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      edr_q     <= '0;
      ie_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      edr_q     <= edr_d;
      ie_q      <= ie_d;
      rd_pend_q <= rd_pend_d;
    end
  end

  // ---------------------------------------------------------------- timers
  ee_countdown #(.W(MW)) u_arm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (ctrl_wr && io_wdata[CB_ARM] && !start_w),
    .clr      (start_w || (ctrl_wr && !io_wdata[CB_ARM])),
    .load_val (MW'(MWE_WINDOW)),
    .active   (arm_act)
  );

  ee_countdown #(.W(TW)) u_wr_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (start_w),
    .clr      (1'b0),
    .load_val (TW'(WR_CYCLES)),
    .active   (wr_busy)
  );

  ee_countdown #(.W(SW)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (start_w || start_r),
    .clr      (1'b0),
    .load_val (start_w ? SW'(WR_STALL) : SW'(RD_STALL)),
    .active   (cpu_stall)
  );

  // ---------------------------------------------------------------- array
  ee_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk   (clk),
    .we    (start_w),
    .waddr (ear_q),
    .wdata (edr_q),
    .raddr (ear_q),
    .rdata (arr_rdata)
  );

  // ---------------------------------------------------------------- read mux
  always_comb begin
    io_rdata = '0;
    if (io_re) begin
      case (sel)
        SEL_ADDR: io_rdata = {{(DW-AW){1'b0}}, ear_q};
        SEL_DATA: io_rdata = edr_q;
        SEL_CTRL: io_rdata = {{(DW-4){1'b0}}, ie_q, arm_act, wr_busy, rd_pend_q};
        default:  io_rdata = '0;
      endcase
    end
  end

  assign ee_rdy_irq = ie_q && gie && !wr_busy;

  // ---------------------------------------------------------------- checks
  logic [MW:0] arm_age_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)                                  arm_age_q <= '0;
    else if (!arm_act || (ctrl_wr && io_wdata[CB_ARM])) arm_age_q <= '0;
    else                                             arm_age_q <= arm_age_q + 1'b1;
  end

  AST_ARM_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n_int)
    arm_act |-> (arm_age_q < (MW+1)'(MWE_WINDOW))); // R5

  AST_WR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(wr_busy) |-> $past(arm_act)); // R4

  AST_WR_STALLS: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(wr_busy) |-> cpu_stall); // R9

  AST_RD_STALLS: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rd_pend_q) |-> cpu_stall); // R9

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_pend_q |=> !rd_pend_q); // R7

  AST_RD_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_busy && ctrl_wr && io_wdata[CB_RD]) |=> !rd_pend_q); // R8

  AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_busy |-> !ee_rdy_irq); // R10

  AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (io_re && io_addr == OFS_ADDR) |-> (io_rdata[DW-1:AW] == '0)); // R2
endmodule

// File: tb/test_eeprom_io_ctrl.sv
module test_eeprom_io_ctrl;
  localparam int WR   = 24;
  localparam int ARMW = 4;
  localparam logic [5:0] A_ADDR = 6'h1E;
  localparam logic [5:0] A_DATA = 6'h1D;
  localparam logic [5:0] A_CTRL = 6'h1C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] io_addr;
  logic       io_we, io_re, gie;
  logic [7:0] io_wdata, io_rdata;
  logic       cpu_stall, ee_rdy_irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  eeprom_io_ctrl #(.WR_CYCLES(WR), .MWE_WINDOW(ARMW)) i_eeprom_io_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we), .io_re(io_re),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gie(gie),
    .cpu_stall(cpu_stall), .ee_rdy_irq(ee_rdy_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ------------------------------------------------ reference model
  int m_ear = -1, m_edr = 0, m_ie = 0, m_arm = 0, m_busy = 0, m_rd = 0, m_stall = 0;
  int mem [64];
  int s1 = 0, s2 = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = -1;

  task automatic model_reset();
    m_edr = 0; m_ie = 0; m_arm = 0; m_busy = 0; m_rd = 0; m_stall = 0;
  endtask

  always @(posedge clk) begin
    int o_ear, o_edr, o_arm, o_busy, o_rd, old_s2;
    bit cw, sw, sr;
    if (!rst_n) begin
      s1 = 0; s2 = 0; model_reset();
    end else begin
      old_s2 = s2; s2 = s1; s1 = 1;
      if (old_s2 == 0) model_reset();
      else begin
        o_ear = m_ear; o_edr = m_edr; o_arm = m_arm; o_busy = m_busy; o_rd = m_rd;
        cw = io_we && (io_addr == A_CTRL);
        sw = cw && io_wdata[1] && (o_arm > 0) && (o_busy == 0);
        sr = cw && io_wdata[0] && (o_busy == 0) && !sw;
        if (o_rd != 0) m_edr = (o_ear >= 0) ? mem[o_ear] : -1;
        else if (io_we && io_addr == A_DATA) m_edr = int'(io_wdata);
        if (sw && o_ear >= 0) mem[o_ear] = o_edr;
        if (io_we && io_addr == A_ADDR) m_ear = int'(io_wdata) & 63;
        if (cw) m_ie = int'(io_wdata[3]);
        if (sw) m_arm = 0;
        else if (cw) m_arm = io_wdata[2] ? ARMW : 0;
        else if (m_arm > 0) m_arm--;
        if (sw) m_busy = WR; else if (m_busy > 0) m_busy--;
        m_rd = sr ? 1 : 0;
        if (sw) m_stall = 2; else if (sr) m_stall = 4; else if (m_stall > 0) m_stall--;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int exp_rd;
    #2;
    if (rst_n) begin
      chk("R9 stall vs model", int'(cpu_stall), (m_stall > 0) ? 1 : 0);
      chk("R10 irq vs model", int'(ee_rdy_irq),
          (m_ie != 0 && gie && m_busy == 0) ? 1 : 0);
      exp_rd = 0;
      if (io_re) begin
        if (io_addr == A_ADDR) exp_rd = m_ear;
        else if (io_addr == A_DATA) exp_rd = m_edr;
        else if (io_addr == A_CTRL)
          exp_rd = (m_ie << 3) | ((m_arm > 0) << 2) | ((m_busy > 0) << 1) | m_rd;
      end
      if (exp_rd >= 0) chk("R1 rdata vs model", int'(io_rdata), exp_rd);
    end
  end

  // ------------------------------------------------ bus tasks
  task automatic cyc(input bit we, input bit re, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_we = we; io_re = re; io_addr = a; io_wdata = d;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'h00, 8'h00);
  endtask

  task automatic rd_exp(input logic [5:0] a, input int exp, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00);
    #3;
    chk(tag, int'(io_rdata), exp);
  endtask

  // polls control each cycle, counting stall, busy and read-pending cycles
  task automatic measure(input int n, output int nst, output int nbz, output int nrd);
    nst = 0; nbz = 0; nrd = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b1, A_CTRL, 8'h00);
      #3;
      if (cpu_stall) nst++;
      if (io_rdata[1]) nbz++;
      if (io_rdata[0]) nrd++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; io_we = 0; io_re = 0;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int nst, nbz, nrd;
    rst_n = 1'b0; io_we = 0; io_re = 0; io_addr = 0; io_wdata = 0; gie = 1'b0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R11 / R3: reset state
    rd_exp(A_CTRL, 0, "R11 control after reset");
    rd_exp(A_DATA, 0, "R3 data after reset");
    chk("R11 stall after reset", int'(cpu_stall), 0);
    chk("R11 irq after reset", int'(ee_rdy_irq), 0);

    // R2: upper address bits read zero
    wr(A_ADDR, 8'hFF);
    rd_exp(A_ADDR, 8'h3F, "R2 address upper bits");
    wr(A_ADDR, 8'h05);
    wr(A_DATA, 8'hA5);
    rd_exp(A_DATA, 8'hA5, "R3 data register write");

    // R4: start without arming, and start with arm in the same write
    wr(A_CTRL, 8'h02);
    rd_exp(A_CTRL, 0, "R4 start without arm refused");
    wr(A_CTRL, 8'h06);
    rd_exp(A_CTRL, 8'h04, "R4 arm+start same write refused");
    idle(6);

    // R6 / R9: proper write of 0xA5 to byte 5
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h02);
    measure(WR + 6, nst, nbz, nrd);
    chk("R9 write stall cycles", nst, 2);
    chk("R6 write busy cycles", nbz, WR);

    // write 0x3C to byte 63
    wr(A_ADDR, 8'd63);
    wr(A_DATA, 8'h3C);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h02);
    idle(WR + 2);

    // R7 / R9: read back
    wr(A_DATA, 8'h00);
    wr(A_ADDR, 8'h05);
    wr(A_CTRL, 8'h01);
    measure(8, nst, nbz, nrd);
    chk("R9 read stall cycles", nst, 4);
    chk("R7 read pending cycles", nrd, 1);
    rd_exp(A_DATA, 8'hA5, "R7 read byte 5");
    wr(A_ADDR, 8'd63);
    wr(A_CTRL, 8'h01);
    idle(6);
    rd_exp(A_DATA, 8'h3C, "R6 read byte 63");

    // R5: window edges
    wr(A_ADDR, 8'd10);
    wr(A_DATA, 8'h5A);
    wr(A_CTRL, 8'h04);
    idle(3);
    wr(A_CTRL, 8'h02);
    rd_exp(A_CTRL, 8'h02, "R5 start in last window cycle");
    idle(WR + 2);
    wr(A_DATA, 8'h77);
    wr(A_CTRL, 8'h04);
    idle(4);
    wr(A_CTRL, 8'h02);
    rd_exp(A_CTRL, 0, "R5 start after window refused");
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h02);
    rd_exp(A_CTRL, 0, "R5 disarm by writing zero");
    wr(A_CTRL, 8'h01);
    idle(6);
    rd_exp(A_DATA, 8'h5A, "R5 byte 10 untouched");

    // R8: read while busy ignored
    wr(A_DATA, 8'h99);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h02);
    wr(A_DATA, 8'h42);
    wr(A_CTRL, 8'h01);
    idle(6);
    rd_exp(A_DATA, 8'h42, "R8 data kept during busy");
    rd_exp(A_CTRL, 8'h02, "R8 read bit stays clear");
    idle(WR);
    wr(A_CTRL, 8'h01);
    idle(6);
    rd_exp(A_DATA, 8'h99, "R6 byte 10 rewritten");

    // R10: interrupt
    gie = 1'b1;
    wr(A_CTRL, 8'h08);
    idle(1); #3;
    chk("R10 irq idle enabled", int'(ee_rdy_irq), 1);
    wr(A_CTRL, 8'h0C);
    wr(A_CTRL, 8'h0A);
    idle(1); #3;
    chk("R10 irq low while busy", int'(ee_rdy_irq), 0);
    idle(WR + 2); #3;
    chk("R10 irq back after write", int'(ee_rdy_irq), 1);
    gie = 1'b0;
    idle(1); #3;
    chk("R10 irq gated by gie", int'(ee_rdy_irq), 0);

    // R2 / R3 / R11: reset keeps address, clears the rest
    wr(A_ADDR, 8'h2A);
    do_reset();
    rd_exp(A_ADDR, 8'h2A, "R2 address kept through reset");
    rd_exp(A_DATA, 0, "R3 data cleared by reset");
    rd_exp(A_CTRL, 0, "R11 control cleared by reset");

    // R1: unmapped offset and idle read strobe
    rd_exp(6'h00, 0, "R1 unmapped offset");
    cyc(1'b0, 1'b0, A_DATA, 8'h00);
    #3;
    chk("R1 rdata low without io_re", int'(io_rdata), 0);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule